// File: doc/BRIEF.md
# Bufferless Ring Stop Router

This block is one stop on a bidirectional ring that has no buffering inside the ring. Each direction (clockwise and counter-clockwise) has its own lane. A lane has two registers in its path. The first is a link register that captures the arriving slot. The second is a router register that drives the next hop. Traffic already on the ring always wins. A flit addressed to this node is taken off into that direction's ejector. Every other flit goes straight through unchanged.

The local core pushes new flits through a single push port. Each flit is steered into the injection queue of the direction with fewer hops to its destination. A queued flit enters its lane only in a cycle where the slot is empty once ejection has been done, so both lanes can inject in the same cycle.

Each lane counts the cycles its head flit has been kept waiting. When a lane has waited long enough, the block raises a starvation request to an external throttle controller. While the throttle input is high, this node holds back new flits, unless its own request is active. In that case it keeps trying until the waiting flit gets onto the ring.

Top module: `ring_stop_router`

## Requirements
- R1: A ring flit whose destination differs from NODE_ID leaves on the same direction's output two clock edges after it is presented, with destination and payload unchanged.
- R2: A ring flit whose destination equals NODE_ID appears on that direction's ejector two clock edges after it is presented, with its payload. It is not forwarded on the ring output.
- R3: Flits for this node arriving on both directions in the same cycle are ejected in the same cycle.
- R4: A queued flit is never placed into a slot occupied by a passing ring flit. The passing flit continues unchanged while the queued flit waits.
- R5: When its slot is free and nothing holds it back, a pushed flit appears on its direction's output two clock edges after the push. Both directions can inject in the same cycle, and a queue drains one flit per free cycle.
- R6: The clockwise hop count is (dst - NODE_ID) mod NUM_NODES, and the counter-clockwise hop count is NUM_NODES minus that (0 for dst equal to NODE_ID). The flit is queued clockwise when the clockwise count is less than or equal to the other, so a tie goes clockwise.
- R7: `starve_req` rises once a lane's head flit has been blocked for STARVE_LIMIT consecutive cycles. It falls in the cycle that flit is injected.
- R8: While `throttle` is high and `starve_req` is low, no new flit is injected in either direction.
- R9: While `starve_req` is high, `throttle` is ignored, so a starving flit injects even under a throttle held high throughout.
- R10: `cw_full` or `ccw_full` is high when FIFO_DEPTH flits are queued in that direction, and low once the queue drains. A push into a full queue is a protocol violation.
- R11: After reset, all ring outputs, ejector valids, full flags and `starve_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_in_vld | input | 1 | Clockwise arriving slot occupied |
| cw_in_dst | input | $clog2(NUM_NODES) | Clockwise arriving destination |
| cw_in_dat | input | DATA_W | Clockwise arriving payload |
| ccw_in_vld | input | 1 | Counter-clockwise arriving slot occupied |
| ccw_in_dst | input | $clog2(NUM_NODES) | Counter-clockwise arriving destination |
| ccw_in_dat | input | DATA_W | Counter-clockwise arriving payload |
| cw_out_vld | output | 1 | Clockwise departing slot occupied |
| cw_out_dst | output | $clog2(NUM_NODES) | Clockwise departing destination |
| cw_out_dat | output | DATA_W | Clockwise departing payload |
| ccw_out_vld | output | 1 | Counter-clockwise departing slot occupied |
| ccw_out_dst | output | $clog2(NUM_NODES) | Counter-clockwise departing destination |
| ccw_out_dat | output | DATA_W | Counter-clockwise departing payload |
| cw_ej_vld | output | 1 | Clockwise ejector valid |
| cw_ej_dat | output | DATA_W | Clockwise ejector payload |
| ccw_ej_vld | output | 1 | Counter-clockwise ejector valid |
| ccw_ej_dat | output | DATA_W | Counter-clockwise ejector payload |
| inj_push | input | 1 | Core pushes a new flit |
| inj_dst | input | $clog2(NUM_NODES) | Destination of pushed flit |
| inj_dat | input | DATA_W | Payload of pushed flit |
| cw_full | output | 1 | Clockwise injection queue full |
| ccw_full | output | 1 | Counter-clockwise injection queue full |
| throttle | input | 1 | Hold back new injections |
| starve_req | output | 1 | This node is starved and asks for a throttle |

## Verification
The hardest situations to reach are the starvation and exemption paths. Both need a queued flit to be blocked for more than a hundred consecutive cycles. The bench holds the clockwise input occupied with pass-through traffic for 130 cycles and then opens a single slot. In a second run it keeps `throttle` high on an empty ring, and checks that the waiting flit still gets out shortly after the limit and that the request pulse is seen.

// File: rtl/ring_stop_pkg.sv
package ring_stop_pkg;
   localparam int LANE_CW  = 0;
   localparam int LANE_CCW = 1;
   localparam int N_LANES  = 2;

   // hops travelled clockwise from node 'me' to node 'dst'
   function automatic int cw_hops(int dst, int me, int n);
      return (dst >= me) ? dst - me : dst + n - me;
   endfunction
endpackage

// File: rtl/ring_stop_fifo.sv
module ring_stop_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ring_stop_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/ring_stop_starve.sv
module ring_stop_starve #(
   parameter int LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   input  logic fired,
   output logic starved
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("ring_stop_starve: LIMIT must be positive");
   end

   logic [CW-1:0] cnt;

   assign starved = (cnt == CW'(LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (fired || !waiting) cnt <= '0;
      else if (!starved)          cnt <= cnt + 1'b1;
   end

   // R7
   starve_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (starved && waiting && !fired) |=> starved);
   // R7
   starve_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fired |=> !starved);
endmodule

// File: rtl/ring_stop_lane.sv
module ring_stop_lane #(
   parameter int NODE_ID = 0,
   parameter int ID_W    = 3,
   parameter int DATA_W  = 32,
   parameter int DEPTH   = 4,
   parameter int LIMIT   = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [ID_W-1:0]   in_dst,
   input  logic [DATA_W-1:0] in_dat,
   output logic              out_vld,
   output logic [ID_W-1:0]   out_dst,
   output logic [DATA_W-1:0] out_dat,
   output logic              ej_vld,
   output logic [DATA_W-1:0] ej_dat,
   input  logic              push,
   input  logic [ID_W-1:0]   push_dst,
   input  logic [DATA_W-1:0] push_dat,
   output logic              full,
   input  logic              throttle,
   input  logic              exempt,
   output logic              starved
);
   localparam int FW = ID_W + DATA_W;
   localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

   logic              lk_vld;
   logic [ID_W-1:0]   lk_dst;
   logic [DATA_W-1:0] lk_dat;
   logic [FW-1:0]     head;
   logic              q_empty, is_mine, slot_busy, fire;

   ring_stop_fifo #(.DEPTH(DEPTH), .W(FW)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata({push_dst, push_dat}),
      .pop(fire), .rdata(head), .empty(q_empty), .full(full)
   );

   ring_stop_starve #(.LIMIT(LIMIT)) u_starve (
      .clk(clk), .rst_n(rst_n), .waiting(!q_empty), .fired(fire), .starved(starved)
   );

   assign is_mine   = lk_vld && (lk_dst == MY_ID);
   assign slot_busy = lk_vld && !is_mine;
   assign fire      = !q_empty && !slot_busy && (!throttle || exempt);

   // link traversal register
   always_ff @(posedge clk) begin
      if (!rst_n) lk_vld <= 1'b0;
      else        lk_vld <= in_vld;
      lk_dst <= in_dst;
      lk_dat <= in_dat;
   end

   // router stage register: ring traffic first, then injection
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         ej_vld  <= 1'b0;
      end else begin
         out_vld <= slot_busy || fire;
         ej_vld  <= is_mine;
      end
      out_dst <= slot_busy ? lk_dst : head[FW-1 -: ID_W];
      out_dat <= slot_busy ? lk_dat : head[DATA_W-1:0];
      ej_dat  <= lk_dat;
   end

   // R1
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_vld && lk_dst != MY_ID) |=>
         (out_vld && out_dst == $past(lk_dst) && out_dat == $past(lk_dat)));
   // R2
   eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_vld && lk_dst == MY_ID) |=> (ej_vld && ej_dat == $past(lk_dat)));
   // R8
   throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (throttle && !exempt && !lk_vld) |=> !out_vld);
endmodule

// File: rtl/ring_stop_router.sv
module ring_stop_router
   import ring_stop_pkg::*;
#(
   parameter int NUM_NODES    = 8,
   parameter int NODE_ID      = 0,
   parameter int DATA_W       = 32,
   parameter int FIFO_DEPTH   = 4,
   parameter int STARVE_LIMIT = 100
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cw_in_vld,
   input  logic [$clog2(NUM_NODES)-1:0] cw_in_dst,
   input  logic [DATA_W-1:0]            cw_in_dat,
   input  logic                         ccw_in_vld,
   input  logic [$clog2(NUM_NODES)-1:0] ccw_in_dst,
   input  logic [DATA_W-1:0]            ccw_in_dat,
   output logic                         cw_out_vld,
   output logic [$clog2(NUM_NODES)-1:0] cw_out_dst,
   output logic [DATA_W-1:0]            cw_out_dat,
   output logic                         ccw_out_vld,
   output logic [$clog2(NUM_NODES)-1:0] ccw_out_dst,
   output logic [DATA_W-1:0]            ccw_out_dat,
   output logic                         cw_ej_vld,
   output logic [DATA_W-1:0]            cw_ej_dat,
   output logic                         ccw_ej_vld,
   output logic [DATA_W-1:0]            ccw_ej_dat,
   input  logic                         inj_push,
   input  logic [$clog2(NUM_NODES)-1:0] inj_dst,
   input  logic [DATA_W-1:0]            inj_dat,
   output logic                         cw_full,
   output logic                         ccw_full,
   input  logic                         throttle,
   output logic                         starve_req
);
   localparam int ID_W = $clog2(NUM_NODES);

   if (NUM_NODES < 2) begin : g_bad_nodes
      $error("ring_stop_router: NUM_NODES must be at least 2");
   end
   if (NODE_ID < 0 || NODE_ID >= NUM_NODES) begin : g_bad_id
      $error("ring_stop_router: NODE_ID out of range");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ring_stop_router: DATA_W must be positive");
   end

   logic [N_LANES-1:0]             l_in_vld, l_out_vld, l_ej_vld, l_push, l_full, l_starved;
   logic [N_LANES-1:0][ID_W-1:0]   l_in_dst, l_out_dst;
   logic [N_LANES-1:0][DATA_W-1:0] l_in_dat, l_out_dat, l_ej_dat;
   logic                           go_cw;
   int                             hops_cw, hops_ccw;

   assign l_in_vld[LANE_CW]  = cw_in_vld;
   assign l_in_dst[LANE_CW]  = cw_in_dst;
   assign l_in_dat[LANE_CW]  = cw_in_dat;
   assign l_in_vld[LANE_CCW] = ccw_in_vld;
   assign l_in_dst[LANE_CCW] = ccw_in_dst;
   assign l_in_dat[LANE_CCW] = ccw_in_dat;

   always_comb begin
      hops_cw  = cw_hops(int'(inj_dst), NODE_ID, NUM_NODES);
      hops_ccw = (hops_cw == 0) ? 0 : NUM_NODES - hops_cw;
      go_cw    = (hops_cw <= hops_ccw);
   end

   assign l_push[LANE_CW]  = inj_push && go_cw;
   assign l_push[LANE_CCW] = inj_push && !go_cw;
   assign starve_req       = |l_starved;

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      ring_stop_lane #(
         .NODE_ID(NODE_ID), .ID_W(ID_W), .DATA_W(DATA_W),
         .DEPTH(FIFO_DEPTH), .LIMIT(STARVE_LIMIT)
      ) u_lane (
         .clk(clk), .rst_n(rst_n),
         .in_vld(l_in_vld[g]), .in_dst(l_in_dst[g]), .in_dat(l_in_dat[g]),
         .out_vld(l_out_vld[g]), .out_dst(l_out_dst[g]), .out_dat(l_out_dat[g]),
         .ej_vld(l_ej_vld[g]), .ej_dat(l_ej_dat[g]),
         .push(l_push[g]), .push_dst(inj_dst), .push_dat(inj_dat),
         .full(l_full[g]), .throttle(throttle), .exempt(starve_req),
         .starved(l_starved[g])
      );
   end

   assign cw_out_vld  = l_out_vld[LANE_CW];
   assign cw_out_dst  = l_out_dst[LANE_CW];
   assign cw_out_dat  = l_out_dat[LANE_CW];
   assign ccw_out_vld = l_out_vld[LANE_CCW];
   assign ccw_out_dst = l_out_dst[LANE_CCW];
   assign ccw_out_dat = l_out_dat[LANE_CCW];
   assign cw_ej_vld   = l_ej_vld[LANE_CW];
   assign cw_ej_dat   = l_ej_dat[LANE_CW];
   assign ccw_ej_vld  = l_ej_vld[LANE_CCW];
   assign ccw_ej_dat  = l_ej_dat[LANE_CCW];
   assign cw_full     = l_full[LANE_CW];
   assign ccw_full    = l_full[LANE_CCW];

   // R6
   steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inj_push |-> $onehot(l_push));
endmodule

// File: tb/ring_stop_router_tb.sv
`timescale 1ns/1ps
module ring_stop_router_tb;
   localparam int N     = 8;
   localparam int ME    = 3;
   localparam int DW    = 16;
   localparam int DEP   = 4;
   localparam int LIM   = 100;
   localparam int IW    = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cw_in_vld = 0, ccw_in_vld = 0, inj_push = 0, throttle = 0;
   logic [IW-1:0] cw_in_dst = '0, ccw_in_dst = '0, inj_dst = '0;
   logic [DW-1:0] cw_in_dat = '0, ccw_in_dat = '0, inj_dat = '0;
   logic cw_out_vld, ccw_out_vld, cw_ej_vld, ccw_ej_vld, cw_full, ccw_full, starve_req;
   logic [IW-1:0] cw_out_dst, ccw_out_dst;
   logic [DW-1:0] cw_out_dat, ccw_out_dat, cw_ej_dat, ccw_ej_dat;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   ring_stop_router #(.NUM_NODES(N), .NODE_ID(ME), .DATA_W(DW),
                      .FIFO_DEPTH(DEP), .STARVE_LIMIT(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cw_in_vld(cw_in_vld), .cw_in_dst(cw_in_dst), .cw_in_dat(cw_in_dat),
      .ccw_in_vld(ccw_in_vld), .ccw_in_dst(ccw_in_dst), .ccw_in_dat(ccw_in_dat),
      .cw_out_vld(cw_out_vld), .cw_out_dst(cw_out_dst), .cw_out_dat(cw_out_dat),
      .ccw_out_vld(ccw_out_vld), .ccw_out_dst(ccw_out_dst), .ccw_out_dat(ccw_out_dat),
      .cw_ej_vld(cw_ej_vld), .cw_ej_dat(cw_ej_dat),
      .ccw_ej_vld(ccw_ej_vld), .ccw_ej_dat(ccw_ej_dat),
      .inj_push(inj_push), .inj_dst(inj_dst), .inj_dat(inj_dat),
      .cw_full(cw_full), .ccw_full(ccw_full),
      .throttle(throttle), .starve_req(starve_req)
   );

   // {cw_vld, cw_dst[2:0], ccw_vld, ccw_dst[2:0], tag[7:0]}
   localparam logic [15:0] VEC [8] = '{
      {1'b1, 3'd5, 1'b1, 3'd1, 8'h11},
      {1'b1, 3'd3, 1'b0, 3'd0, 8'h22},
      {1'b0, 3'd0, 1'b1, 3'd3, 8'h33},
      {1'b1, 3'd3, 1'b1, 3'd3, 8'h44},
      {1'b1, 3'd0, 1'b1, 3'd7, 8'h55},
      {1'b1, 3'd3, 1'b1, 3'd6, 8'h66},
      {1'b0, 3'd0, 1'b0, 3'd0, 8'h00},
      {1'b1, 3'd2, 1'b1, 3'd3, 8'h77}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic push(input logic [IW-1:0] d, input logic [DW-1:0] v);
      @(negedge clk);
      inj_push = 1'b1; inj_dst = d; inj_dat = v;
      @(negedge clk);
      inj_push = 1'b0;
   endtask

   function automatic bit pick_cw(input int d);
      int hc, hk;
      hc = (d >= ME) ? d - ME : d + N - ME;
      hk = (hc == 0) ? 0 : N - hc;
      return hc <= hk;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 out", {cw_out_vld, ccw_out_vld, cw_ej_vld, ccw_ej_vld}, 0);
      check("R11 flags", {cw_full, ccw_full, starve_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3: table of ring arrivals
      for (int i = 0; i < 8; i++) begin
         logic cv, kv; logic [2:0] cd, kd; logic [7:0] tg;
         {cv, cd, kv, kd, tg} = VEC[i];
         cw_in_vld = cv; cw_in_dst = cd; cw_in_dat = {tg, 8'hA5};
         ccw_in_vld = kv; ccw_in_dst = kd; ccw_in_dat = {tg, 8'h5A};
         @(negedge clk);
         cw_in_vld = 0; ccw_in_vld = 0;
         @(negedge clk);
         check("R1 cw pass vld", cw_out_vld, cv && cd != ME);
         if (cv && cd != ME) check("R1 cw pass data", {cw_out_dst, cw_out_dat}, {cd, tg, 8'hA5});
         check("R1 ccw pass vld", ccw_out_vld, kv && kd != ME);
         if (kv && kd != ME) check("R1 ccw pass data", {ccw_out_dst, ccw_out_dat}, {kd, tg, 8'h5A});
         check("R2 cw eject vld", cw_ej_vld, cv && cd == ME);
         if (cv && cd == ME) check("R2 cw eject data", cw_ej_dat, {tg, 8'hA5});
         check("R3 ccw eject vld", ccw_ej_vld, kv && kd == ME);
         if (kv && kd == ME) check("R3 ccw eject data", ccw_ej_dat, {tg, 8'h5A});
      end

      // R6 direction choice, including the tie at dst 7
      for (int d = 0; d < N; d++) begin
         if (d == ME) continue;
         push(IW'(d), DW'(16'hC000 + d));
         @(negedge clk);
         check("R6 cw chosen", cw_out_vld, pick_cw(d));
         check("R6 ccw chosen", ccw_out_vld, !pick_cw(d));
         check("R5 inject data", pick_cw(d) ? cw_out_dat : ccw_out_dat, 16'hC000 + d);
         @(negedge clk);
      end

      // R8 then R5: both lanes held, then inject together
      throttle = 1'b1;
      push(3'd5, 16'h0A0A);
      push(3'd0, 16'h0B0B);
      @(negedge clk);
      check("R8 throttled", {cw_out_vld, ccw_out_vld}, 0);
      throttle = 1'b0;
      @(negedge clk);
      check("R5 dual inject", {cw_out_vld, ccw_out_vld}, 2'b11);
      check("R5 dual data", {cw_out_dat, ccw_out_dat}, {16'h0A0A, 16'h0B0B});
      @(negedge clk);

      // R10 full flag and drain
      throttle = 1'b1;
      for (int k = 0; k < DEP; k++) push(3'd0, DW'(16'hD000 + k));
      check("R10 ccw full", ccw_full, 1'b1);
      check("R10 cw not full", cw_full, 1'b0);
      throttle = 1'b0;
      begin
         int seen = 0;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (ccw_out_vld) seen++;
         end
         check("R5 drain count", seen, DEP);
      end
      check("R10 ccw not full", ccw_full, 1'b0);

      // R4 R7: ring kept busy, flit starves
      cw_in_vld = 1'b1; cw_in_dst = 3'd5; cw_in_dat = 16'hBEEF;
      push(3'd5, 16'h1234);
      repeat (60) @(negedge clk);
      check("R7 not yet", starve_req, 1'b0);
      check("R4 ring priority", {cw_out_vld, cw_out_dat}, {1'b1, 16'hBEEF});
      repeat (70) @(negedge clk);
      check("R7 raised", starve_req, 1'b1);
      cw_in_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R4 injects into free slot", {cw_out_vld, cw_out_dat}, {1'b1, 16'h1234});
      check("R7 dropped", starve_req, 1'b0);
      @(negedge clk);

      // R9: throttle held, starved node still injects
      throttle = 1'b1;
      push(3'd5, 16'h5555);
      begin
         bit got = 0, req_seen = 0;
         int at = 0;
         for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (k == 50) check("R8 held under throttle", cw_out_vld, 1'b0);
            if (starve_req) req_seen = 1;
            if (cw_out_vld && !got) begin got = 1; at = k; end
         end
         check("R9 injected", got, 1'b1);
         check("R9 after limit", at >= LIM - 2, 1'b1);
         check("R9 request seen", req_seen, 1'b1);
      end
      throttle = 1'b0;

      done = 1;
      finish_run();
   end
endmodule